// File: doc/BRIEF.md
# Eight-Pin GPIO Bank with Atomic Output Aliases

This block is one bank of general-purpose pins behind a small 32-bit register bus. It has an address, a write strobe, write data and a combinational read-data port. Software drives the pins through an output-data register. That register can be loaded whole, or changed bit-wise through three write-only aliases: one sets bits, one clears bits and one inverts bits. Software does not need a read-modify-write sequence, so two agents that each own different pins cannot overwrite each other's changes.

Each pin also has a two-bit mode field and a digital input-enable bit. The mode bits, output bits and enable bits leave the block as plain signals for the pad ring. Pin levels come in from a global pin array. A parameter picks the eight-pin slice that belongs to this bank. Each pin level passes through a two-flop synchronizer and is then captured into an input register. A pin's captured value is refreshed only while its input enable is on, and otherwise it keeps its last value.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is zero: every offset reads zero, and `pad_dout`, `pad_mode` and `pad_ien` are all zero.
- R2: The mode register at byte offset 0x04 stores bits 15:0 of a write, with pin n in bits 2n+1:2n, and drives them on `pad_mode`. In the 8-bit registers (0x00, 0x08, 0x18), bits 31:8 read as zero. In the mode register, bits 31:16 read as zero.
- R3: A write to offset 0x00 loads bits 7:0 into the output register, on the rising edge where `bus_we` is high. The value appears on `pad_dout` and reads back at 0x00.
- R4: A write to offset 0x0C sets each output bit whose written bit is 1 and leaves the other output bits unchanged.
- R5: A write to offset 0x10 clears each output bit whose written bit is 1 and leaves the other output bits unchanged.
- R6: A write to offset 0x14 inverts each output bit whose written bit is 1 and leaves the other output bits unchanged.
- R7: Reads of offsets 0x0C, 0x10 and 0x14 always return zero.
- R8: While a pin's input enable (offset 0x18, bit n, also on `pad_ien`) is 1, a level change on that pin shows in bit n of offset 0x08 after the third rising edge. It does not show after the second rising edge.
- R9: While a pin's input enable is 0, its bit at offset 0x08 keeps its last captured value. The enable that governs a capture is the value held before that edge. A write that clears the enable therefore still lets the sample arriving on the same edge through.
- R10: Writes to offset 0x08 and to unmapped offsets (for example 0x1C or 0x01) change no register. Unmapped offsets read zero.
- R11: Local bit n of the bank serves global pin 8*BANK_IDX+n. Levels on pins outside that slice have no effect on offset 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pins_in | input | 16 | Global pin level array |
| pad_dout | output | 8 | Output levels for the bank's pins |
| pad_mode | output | 16 | Two mode bits per pin |
| pad_ien | output | 8 | Digital input enable per pin |

## Verification
Two functions can meet on the same clock edge: a bus write that clears an input enable, and the synchronized pin sample that reaches the capture register on that edge. The bench changes a pin, waits exactly two edges so the new level sits at the end of the synchronizer, and then issues the enable-clearing write. The new level must be captured, and later pin changes must not be. A second meeting point is an alias write together with the bits it leaves untouched. This is judged against a bench model of the output register after every set, clear and toggle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam logic [7:0] OFS_DOUT = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_DIN  = 8'h08;
    localparam logic [7:0] OFS_SET  = 8'h0C;
    localparam logic [7:0] OFS_CLR  = 8'h10;
    localparam logic [7:0] OFS_TGL  = 8'h14;
    localparam logic [7:0] OFS_IEN  = 8'h18;

    typedef struct packed {
        logic ld_dout;
        logic ld_mode;
        logic set_dout;
        logic clr_dout;
        logic tgl_dout;
        logic ld_ien;
    } wr_strobe_t;

    typedef enum logic [2:0] {
        RD_ZERO,
        RD_DOUT,
        RD_MODE,
        RD_DIN,
        RD_IEN
    } rd_sel_e;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output wr_strobe_t        wr,
    output rd_sel_e           rd_sel
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_comb begin
        wr          = '0;
        wr.ld_dout  = we && hit(addr, OFS_DOUT);
        wr.ld_mode  = we && hit(addr, OFS_MODE);
        wr.set_dout = we && hit(addr, OFS_SET);
        wr.clr_dout = we && hit(addr, OFS_CLR);
        wr.tgl_dout = we && hit(addr, OFS_TGL);
        wr.ld_ien   = we && hit(addr, OFS_IEN);
    end

    always_comb begin
        if (hit(addr, OFS_DOUT))      rd_sel = RD_DOUT;
        else if (hit(addr, OFS_MODE)) rd_sel = RD_MODE;
        else if (hit(addr, OFS_DIN))  rd_sel = RD_DIN;
        else if (hit(addr, OFS_IEN))  rd_sel = RD_IEN;
        else                          rd_sel = RD_ZERO;
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int DATA_W = 32,
    localparam int MODE_W = 2 * PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [PINS-1:0]   dout,
    output logic [MODE_W-1:0] mode,
    output logic [PINS-1:0]   ien
);

    typedef struct packed {
        logic [PINS-1:0]   dout;
        logic [MODE_W-1:0] mode;
        logic [PINS-1:0]   ien;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic [PINS-1:0]   wbits;
    logic [MODE_W-1:0] wmode;

    assign wbits = wdata[PINS-1:0];
    assign wmode = wdata[MODE_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr.ld_dout)  st_d.dout = wbits;
        if (wr.set_dout) st_d.dout = st_q.dout | wbits;
        if (wr.clr_dout) st_d.dout = st_q.dout & ~wbits;
        if (wr.tgl_dout) st_d.dout = st_q.dout ^ wbits;
        if (wr.ld_mode)  st_d.mode = wmode;
        if (wr.ld_ien)   st_d.ien  = wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;
    assign mode = st_q.mode;
    assign ien  = st_q.ien;

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wr.set_dout |=> ((dout & $past(wbits)) == $past(wbits))); // R4
    AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        wr.clr_dout |=> ((dout & $past(wbits)) == '0)); // R5
    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        wr.tgl_dout |=> (dout == ($past(dout) ^ $past(wbits)))); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr == '0) |=> ($stable(dout) && $stable(mode) && $stable(ien))); // R10

endmodule

// File: rtl/gpio_bank_insync.sv
module gpio_bank_insync #(
    parameter int PINS   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_raw,
    input  logic [PINS-1:0] en,
    output logic [PINS-1:0] din
);

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        typedef struct packed {
            logic [STAGES-1:0] chain;
            logic              held;
        } pin_st_t;

        pin_st_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.chain = {st_q.chain[STAGES-2:0], pin_raw[n]};
            if (en[n]) st_d.held = st_q.chain[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign din[n] = st_q.held;

        AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !en[n] |=> $stable(din[n])); // R9
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int BANK_IDX    = 1,
    parameter int PINS        = 8,
    parameter int GLOBAL_PINS = 16,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int MODE_W     = 2 * PINS,
    localparam int SLICE_LO   = BANK_IDX * PINS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [GLOBAL_PINS-1:0] pins_in,
    output logic [PINS-1:0]        pad_dout,
    output logic [MODE_W-1:0]      pad_mode,
    output logic [PINS-1:0]        pad_ien
);

    wr_strobe_t      wr;
    rd_sel_e         rd_sel;
    logic [PINS-1:0] din;
    logic [PINS-1:0] local_pins;

    assign local_pins = pins_in[SLICE_LO +: PINS];

    gpio_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .we     (bus_we),
        .wr     (wr),
        .rd_sel (rd_sel)
    );

    gpio_bank_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr),
        .wdata (bus_wdata),
        .dout  (pad_dout),
        .mode  (pad_mode),
        .ien   (pad_ien)
    );

    gpio_bank_insync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_insync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (local_pins),
        .en      (pad_ien),
        .din     (din)
    );

    always_comb begin
        case (rd_sel)
            RD_DOUT: bus_rdata = DATA_W'(pad_dout);
            RD_MODE: bus_rdata = DATA_W'(pad_mode);
            RD_DIN:  bus_rdata = DATA_W'(din);
            RD_IEN:  bus_rdata = DATA_W'(pad_ien);
            default: bus_rdata = '0;
        endcase
    end

    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:MODE_W] == '0); // R2
    AST_ALIAS_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_SET) || bus_addr == ADDR_W'(OFS_CLR) ||
         bus_addr == ADDR_W'(OFS_TGL)) |-> (bus_rdata == '0)); // R7

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pins_in = '0;
    logic [7:0]  pad_dout;
    logic [15:0] pad_mode;
    logic [7:0]  pad_ien;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_dout = '0;

    always #10 clk = ~clk;

    gpio_bank #(.BANK_IDX(1), .GLOBAL_PINS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in),
        .pad_dout(pad_dout), .pad_mode(pad_mode), .pad_ien(pad_ien)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // All bus tasks start and end just after a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 32; a += 4) begin
            rd(8'(a), v);
            check("R1", $sformatf("reset read %0h", a), v, 0);
        end
        check("R1", "reset pad_dout", {24'h0, pad_dout}, 0);
        check("R1", "reset pad_mode", {16'h0, pad_mode}, 0);
        check("R1", "reset pad_ien",  {24'h0, pad_ien}, 0);
    endtask

    task automatic t_direct();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FF5A); exp_dout = 8'h5A;
        rd(8'h00, v);
        check("R3", "direct load readback", v, 32'h5A);
        check("R2", "dout upper bits zero", v & 32'hFFFF_FF00, 0);
        check("R3", "direct load pad", {24'h0, pad_dout}, {24'h0, exp_dout});
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(8'h0C, 32'h0000_0081); exp_dout = exp_dout | 8'h81;
        check("R4", "set alias", {24'h0, pad_dout}, {24'h0, exp_dout});
        wr(8'h10, 32'h0000_0012); exp_dout = exp_dout & ~8'h12;
        check("R5", "clear alias", {24'h0, pad_dout}, {24'h0, exp_dout});
        wr(8'h14, 32'h0000_00F0); exp_dout = exp_dout ^ 8'hF0;
        check("R6", "toggle alias", {24'h0, pad_dout}, {24'h0, exp_dout});
        wr(8'h0C, 32'h0); wr(8'h10, 32'h0); wr(8'h14, 32'h0);
        rd(8'h00, v);
        check("R4", "zero mask changes nothing", v, {24'h0, exp_dout});
        rd(8'h0C, v); check("R7", "set alias reads zero", v, 0);
        rd(8'h10, v); check("R7", "clear alias reads zero", v, 0);
        rd(8'h14, v); check("R7", "toggle alias reads zero", v, 0);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        wr(8'h04, 32'hABCD_1B6C);
        rd(8'h04, v);
        check("R2", "mode readback", v, 32'h1B6C);
        check("R2", "pin3 mode field", {30'h0, pad_mode[7:6]}, 32'h1);
        check("R2", "pin7 mode field", {30'h0, pad_mode[15:14]}, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(8'h08, 32'hFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R10", "dout untouched", v, {24'h0, exp_dout});
        rd(8'h04, v); check("R10", "mode untouched", v, 32'h1B6C);
        rd(8'h18, v); check("R10", "ien untouched", v, 0);
        rd(8'h08, v); check("R10", "din untouched", v, 0);
        rd(8'h1C, v); check("R10", "unmapped reads zero", v, 0);
    endtask

    task automatic t_latency();
        logic [31:0] v;
        wr(8'h18, 32'hFF);
        check("R8", "pad_ien", {24'h0, pad_ien}, 32'hFF);
        pins_in[15:8] = 8'h3C; pins_in[7:0] = 8'hA5;
        idle(2);
        rd(8'h08, v); check("R8", "not visible after two edges", v, 0);
        idle(1);
        rd(8'h08, v); check("R8", "visible after three edges", v, 32'h3C);
        check("R11", "only own slice sampled", v, 32'h3C);
        pins_in[7:0] = 8'h00;
        idle(4);
        rd(8'h08, v); check("R11", "other bank pins ignored", v, 32'h3C);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        wr(8'h18, 32'h0F);
        idle(3);
        pins_in[15:8] = 8'hC3;
        idle(5);
        rd(8'h08, v);
        check("R9", "disabled bits hold", v, {24'h0, (8'hC3 & 8'h0F) | (8'h3C & 8'hF0)});
    endtask

    task automatic t_enable_edge();
        logic [31:0] v;
        wr(8'h18, 32'hFF);
        idle(4);
        rd(8'h08, v); check("R9", "re-enable refreshes", v, 32'hC3);
        pins_in[15:8] = 8'h00;
        idle(2);
        wr(8'h18, 32'h00);
        rd(8'h08, v); check("R9", "sample on disabling edge taken", v, 0);
        pins_in[15:8] = 8'hFF;
        idle(5);
        rd(8'h08, v); check("R9", "frozen after disable", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_direct();
        t_alias();
        t_mode();
        t_ignored();
        t_latency();
        t_hold();
        t_enable_edge();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule